// File: doc/BRIEF.md
# Sync-Word Framed Byte Stream Extractor

This block watches an incoming byte stream, delivered with a valid/ready handshake, and pulls framed payloads out of it. A frame opens with two back-to-back sync bytes of value 0xAA. The byte right after them is an unsigned payload length. A fixed gap of header bytes follows, and the block drops those bytes. The next "length" bytes go out on an output byte stream that has valid, ready and last signals. The block then goes back to hunting for the next sync pair.

The output has a single holding register. The input is stalled only while that register is full and downstream is not ready. A frame counter records how many payloads have been fully delivered downstream. The block does not check the payload and does not interpret it.

Top module: `fse_extractor`

## Requirements
- R1: Synchronous active-high reset. After reset, out_valid is 0, frame_count is 0 and in_ready is 1. A frame that was in progress is abandoned, and the block goes back to hunting.
- R2: A frame starts only on two accepted bytes in a row that both equal 0xAA. A single 0xAA followed by any other byte does not start a frame, and hunting continues.
- R3: The accepted byte immediately after the sync pair is the payload length, an unsigned 8-bit count.
- R4: Exactly SKIP_LEN bytes (default 9) that follow the length byte are consumed and never appear on the output.
- R5: After the gap, exactly "length" input bytes appear on out_data, in arrival order and unchanged. Each one shows up in the cycle after it is accepted.
- R6: out_last is 1 on the final payload byte of a frame and 0 on every other output byte.
- R7: A byte equal to 0xAA inside the gap or the payload is treated as data and does not restart sync detection.
- R8: A length of 0 produces no output bytes. Hunting resumes with the first byte after the gap.
- R9: When out_valid is 1 and out_ready is 0, in_ready is 0, and out_data and out_last hold steady until the byte is taken. No byte is lost or repeated.
- R10: frame_count goes up by one in the cycle after a byte with out_last set is taken downstream. Zero-length frames do not add to the count.
- R11: Bytes that arrive between the end of one payload and the next sync pair produce no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input byte is present |
| in_ready | output | 1 | Block can take the input byte |
| in_data | input | DATA_W | Input byte |
| out_valid | output | 1 | Output byte is present |
| out_ready | input | 1 | Downstream takes the output byte |
| out_data | output | DATA_W | Payload byte |
| out_last | output | 1 | Final payload byte of the frame |
| frame_count | output | CNT_W | Number of payloads fully delivered |

## Verification
A wrong parser state shows up at the output. A missed sync or a miscounted gap either suppresses the whole payload or shifts it by whole bytes. Both are visible on out_data one cycle after the first payload byte would have been accepted. A wrong remaining count moves out_last or leaks extra bytes at the end of the frame, and frame_count then disagrees as soon as the final byte is taken. Holding-register faults appear the first cycle out_ready is low, as a changed held byte or a still-asserted in_ready.

// File: rtl/fse_pkg.sv
package fse_pkg;
  typedef enum logic [2:0] {
    ST_HUNT,
    ST_SEEN1,
    ST_LEN,
    ST_SKIP,
    ST_PAY
  } fse_state_e;
endpackage

// File: rtl/fse_frame_ctrl.sv
module fse_frame_ctrl #(
  parameter int DATA_W = 8,
  parameter logic [DATA_W-1:0] SYNC_BYTE = 8'hAA,
  parameter int SKIP_LEN = 9
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              acc,
  input  logic [DATA_W-1:0] in_data,
  output logic              pay_take,
  output logic              pay_last
);
  import fse_pkg::*;

  localparam int SKIP_W = $clog2(SKIP_LEN + 1);
  localparam logic [SKIP_W-1:0] SKIP_END = SKIP_W'(SKIP_LEN - 1);

  fse_state_e        st_q, st_d;
  logic [SKIP_W-1:0] skip_q, skip_d;
  logic [DATA_W-1:0] rem_q, rem_d;

  always_comb begin
    st_d   = st_q;
    skip_d = skip_q;
    rem_d  = rem_q;
    if (acc) begin
      case (st_q)
        ST_HUNT:  if (in_data == SYNC_BYTE) st_d = ST_SEEN1;
        ST_SEEN1: st_d = (in_data == SYNC_BYTE) ? ST_LEN : ST_HUNT;
        ST_LEN: begin
          rem_d  = in_data;
          skip_d = '0;
          st_d   = ST_SKIP;
        end
        ST_SKIP: begin
          if (skip_q == SKIP_END) begin
            st_d = (rem_q == '0) ? ST_HUNT : ST_PAY;
          end else begin
            skip_d = skip_q + 1'b1;
          end
        end
        ST_PAY: begin
          rem_d = rem_q - 1'b1;
          if (rem_q == DATA_W'(1)) st_d = ST_HUNT;
        end
        default: st_d = ST_HUNT;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q   <= ST_HUNT;
      skip_q <= '0;
      rem_q  <= '0;
    end else begin
      st_q   <= st_d;
      skip_q <= skip_d;
      rem_q  <= rem_d;
    end
  end

  assign pay_take = acc && (st_q == ST_PAY);
  assign pay_last = (rem_q == DATA_W'(1));

  // R2, R3: the length state is entered only straight after an accepted sync byte
  p_len_after_sync_r2: assert property (@(posedge clk) disable iff (rst)
    $rose(st_q == ST_LEN) |-> $past(acc && (in_data == SYNC_BYTE)));

  // R5: the payload state never runs with nothing left to forward
  p_pay_nonzero_r5: assert property (@(posedge clk) disable iff (rst)
    (st_q == ST_PAY) |-> (rem_q != '0));

  // R4: the gap counter stays inside the gap
  p_skip_bound_r4: assert property (@(posedge clk) disable iff (rst)
    (st_q == ST_SKIP) |-> (skip_q <= SKIP_END));

  // R7: once the gap or payload has started, the next step stays in frame or ends it
  p_no_resync_r7: assert property (@(posedge clk) disable iff (rst)
    (st_q == ST_SKIP) |=> (st_q == ST_SKIP || st_q == ST_PAY || st_q == ST_HUNT));
endmodule

// File: rtl/fse_out_stage.sv
module fse_out_stage #(
  parameter int DATA_W = 8,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [DATA_W-1:0] load_data,
  input  logic              load_last,
  input  logic              out_ready,
  output logic              out_valid,
  output logic [DATA_W-1:0] out_data,
  output logic              out_last,
  output logic [CNT_W-1:0]  frame_count
);
  logic done;
  assign done = out_valid && out_ready && out_last;

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_data  <= '0;
      out_last  <= 1'b0;
    end else if (load) begin
      out_valid <= 1'b1;
      out_data  <= load_data;
      out_last  <= load_last;
    end else if (out_ready) begin
      out_valid <= 1'b0;
      out_last  <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) frame_count <= '0;
    else if (done) frame_count <= frame_count + 1'b1;
  end

  // R9: a stalled byte stays put
  p_hold_stable_r9: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_last)));

  // R9: no new byte is loaded over a stalled one
  p_no_overwrite_r9: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |-> !load);

  // R10: each delivered final byte bumps the count by one
  p_count_step_r10: assert property (@(posedge clk) disable iff (rst)
    done |=> (frame_count == $past(frame_count) + 1'b1));

  // R6: last is flagged only on a presented byte
  p_last_valid_r6: assert property (@(posedge clk) disable iff (rst)
    out_last |-> out_valid);
endmodule

// File: rtl/fse_extractor.sv
module fse_extractor #(
  parameter int DATA_W = 8,
  parameter logic [DATA_W-1:0] SYNC_BYTE = 8'hAA,
  parameter int SKIP_LEN = 9,
  parameter int CNT_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DATA_W-1:0] in_data,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [DATA_W-1:0] out_data,
  output logic              out_last,
  output logic [CNT_W-1:0]  frame_count
);
  logic acc, pay_take, pay_last;

  assign in_ready = !out_valid || out_ready;
  assign acc      = in_valid && in_ready;

  fse_frame_ctrl #(
    .DATA_W(DATA_W), .SYNC_BYTE(SYNC_BYTE), .SKIP_LEN(SKIP_LEN)
  ) ctrl_i (
    .clk(clk), .rst(rst), .acc(acc), .in_data(in_data),
    .pay_take(pay_take), .pay_last(pay_last)
  );

  fse_out_stage #(
    .DATA_W(DATA_W), .CNT_W(CNT_W)
  ) ostage_i (
    .clk(clk), .rst(rst), .load(pay_take), .load_data(in_data),
    .load_last(pay_last), .out_ready(out_ready), .out_valid(out_valid),
    .out_data(out_data), .out_last(out_last), .frame_count(frame_count)
  );

  // R1: reset leaves the input open and the output empty
  p_reset_state_r1: assert property (@(posedge clk)
    rst |=> (!out_valid && in_ready && frame_count == '0));
endmodule

// File: tb/fse_extractor_tb_top.sv
module fse_extractor_tb_top;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0;
  logic in_ready;
  logic [7:0] in_data = 8'h00;
  logic out_valid;
  logic out_ready = 1'b1;
  logic [7:0] out_data;
  logic out_last;
  logic [15:0] frame_count;

  int n_chk = 0;
  int n_fail = 0;
  int cyc = 0;

  always #4 clk = ~clk;

  fse_extractor dut_i (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .out_valid(out_valid), .out_ready(out_ready),
    .out_data(out_data), .out_last(out_last), .frame_count(frame_count)
  );

  // {input byte, expect output, expected byte, expected last}
  localparam int NV = 44;
  localparam logic [17:0] VEC [NV] = '{
    {8'h11,1'b0,8'h00,1'b0}, {8'hAA,1'b0,8'h00,1'b0}, {8'h22,1'b0,8'h00,1'b0},
    {8'hAA,1'b0,8'h00,1'b0}, {8'hAA,1'b0,8'h00,1'b0}, {8'h03,1'b0,8'h00,1'b0},
    {8'h01,1'b0,8'h00,1'b0}, {8'hAA,1'b0,8'h00,1'b0}, {8'h02,1'b0,8'h00,1'b0},
    {8'h03,1'b0,8'h00,1'b0}, {8'h04,1'b0,8'h00,1'b0}, {8'h05,1'b0,8'h00,1'b0},
    {8'h06,1'b0,8'h00,1'b0}, {8'h07,1'b0,8'h00,1'b0}, {8'h08,1'b0,8'h00,1'b0},
    {8'h10,1'b1,8'h10,1'b0}, {8'hAA,1'b1,8'hAA,1'b0}, {8'h30,1'b1,8'h30,1'b1},
    {8'h55,1'b0,8'h00,1'b0}, {8'hAA,1'b0,8'h00,1'b0}, {8'hAA,1'b0,8'h00,1'b0},
    {8'h00,1'b0,8'h00,1'b0}, {8'hAA,1'b0,8'h00,1'b0}, {8'hAA,1'b0,8'h00,1'b0},
    {8'hAA,1'b0,8'h00,1'b0}, {8'h00,1'b0,8'h00,1'b0}, {8'h00,1'b0,8'h00,1'b0},
    {8'h00,1'b0,8'h00,1'b0}, {8'h00,1'b0,8'h00,1'b0}, {8'h00,1'b0,8'h00,1'b0},
    {8'h00,1'b0,8'h00,1'b0}, {8'hAA,1'b0,8'h00,1'b0}, {8'hAA,1'b0,8'h00,1'b0},
    {8'h01,1'b0,8'h00,1'b0}, {8'h5A,1'b0,8'h00,1'b0}, {8'h5A,1'b0,8'h00,1'b0},
    {8'h5A,1'b0,8'h00,1'b0}, {8'h5A,1'b0,8'h00,1'b0}, {8'h5A,1'b0,8'h00,1'b0},
    {8'h5A,1'b0,8'h00,1'b0}, {8'h5A,1'b0,8'h00,1'b0}, {8'h5A,1'b0,8'h00,1'b0},
    {8'h5A,1'b0,8'h00,1'b0}, {8'h77,1'b1,8'h77,1'b1}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // drive at a falling edge, let one rising edge take it, return at the next falling edge
  task automatic send(input logic [7:0] b);
    in_valid = 1'b1;
    in_data  = b;
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic do_reset();
    rst = 1'b1;
    in_valid = 1'b0;
    out_ready = 1'b1;
    repeat (2) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      n_fail++;
      $display("FAIL watchdog: actual %0d expected below 100000", cyc);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    do_reset();
    // R1: reset state
    chk("R1 out_valid", 32'(out_valid), 0);
    chk("R1 in_ready", 32'(in_ready), 1);
    chk("R1 frame_count", 32'(frame_count), 0);

    // table walk: R2 R3 R4 R5 R6 R7 R8 R11
    for (int i = 0; i < NV; i++) begin
      send(VEC[i][17:10]);
      chk($sformatf("R5 valid v%0d", i), 32'(out_valid), 32'(VEC[i][9]));
      if (VEC[i][9]) begin
        chk($sformatf("R5 data v%0d", i), 32'(out_data), 32'(VEC[i][8:1]));
        chk($sformatf("R6 last v%0d", i), 32'(out_last), 32'(VEC[i][0]));
      end
    end
    @(negedge clk);
    // R10: two non-empty frames delivered, the zero-length one (R8) not counted
    chk("R10 frame_count", 32'(frame_count), 2);

    // R1: reset mid-frame abandons it
    send(8'hAA); send(8'hAA); send(8'h01);
    do_reset();
    chk("R1 count cleared", 32'(frame_count), 0);
    for (int k = 0; k < 10; k++) begin
      send(8'h3C);
      chk("R1 no output after mid-frame reset", 32'(out_valid), 0);
    end

    // R9: backpressure
    out_ready = 1'b0;
    send(8'hAA); send(8'hAA); send(8'h02);
    for (int k = 0; k < 9; k++) send(8'h00);
    send(8'hC1);
    chk("R9 held valid", 32'(out_valid), 1);
    chk("R9 held data", 32'(out_data), 32'hC1);
    in_valid = 1'b1;
    in_data  = 8'hC2;
    #1;
    chk("R9 in_ready low", 32'(in_ready), 0);
    repeat (3) @(negedge clk);
    chk("R9 data stable", 32'(out_data), 32'hC1);
    chk("R9 last stable", 32'(out_last), 0);
    chk("R9 still stalled", 32'(in_ready), 0);
    out_ready = 1'b1;
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    chk("R9 next byte", 32'(out_data), 32'hC2);
    chk("R6 last on second", 32'(out_last), 1);
    chk("R10 not yet counted", 32'(frame_count), 0);
    @(negedge clk);
    chk("R9 drained", 32'(out_valid), 0);
    chk("R10 counted once", 32'(frame_count), 1);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule